// File: doc/BRIEF.md
# Packed Multimedia Integer ALU

This block performs SIMD-style integer work on two 64-bit operands. A size field picks the lane view, which is eight byte lanes, four halfword lanes or two word lanes. An opcode field picks the operation. The block can add or subtract each lane with wrap-around. It can compare each lane for equality or for signed greater-than, and the answer is a mask. It can interleave the odd-numbered lanes of both sources. It can also narrow both sources into one word, clamping each value to the signed range of the narrower lane.

The operation is decoded and computed in combinational logic and captured in an output register. The result therefore appears one clock after the request. Some pairs of opcode and size have no meaning. For those the block returns zero and raises a flag, so that a pipeline can trap the request.

Top module: `pmx_alu`

## Requirements
- R1: `lane_sz` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes and 2 gives 32-bit lanes. Lane i occupies bits [i*W +: W], with lane 0 at the least significant end.
- R2: Opcode 0 adds `src_a` and `src_b` lane by lane, modulo 2^W. No carry passes from one lane to the next.
- R3: Opcode 1 subtracts `src_b` from `src_a` lane by lane, modulo 2^W. No borrow passes from one lane to the next.
- R4: Opcode 2 makes each result lane all ones when the two source lanes are equal, and all zeros when they differ.
- R5: Opcode 3 makes each result lane all ones when the `src_a` lane is greater than the `src_b` lane as a signed two's-complement value, and all zeros otherwise.
- R6: Opcode 4 interleaves the odd lanes of the sources. For each pair k, result lane 2k+1 takes `src_a` lane 2k+1 and result lane 2k takes `src_b` lane 2k+1.
- R7: Opcode 5 narrows the lanes to half width. With size 1, halfwords become bytes. With size 2, words become halfwords. The narrowed lanes of `src_a` fill the lower 32 result bits in lane order, and the narrowed lanes of `src_b` fill the upper 32 bits.
- R8: When narrowing, a value above the signed maximum of the narrow lane becomes that maximum, and a value below the signed minimum becomes that minimum. A value inside the range is kept unchanged.
- R9: Opcodes 6 and 7 are illegal, size 3 is illegal with any opcode, and opcode 5 is illegal with size 0. An illegal request produces a zero result and sets `out_illegal`.
- R10: `out_valid` equals `in_valid` delayed by one clock. The result and the flag are captured only when `in_valid` is high, and they keep their values otherwise.
- R11: Synchronous reset clears `out_valid`, `out_result` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 3 | Operation select |
| lane_sz | input | 2 | Lane width select |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Registered result |
| out_illegal | output | 1 | Registered illegal-combination flag |

## Verification
The only state in this block is the output register. A fault in the way it is captured shows at the ports one clock after the request that should have loaded it. A result or flag that changes while `in_valid` is low is seen at the next idle cycle. An error in lane slicing usually damages only the lanes at a boundary. For this reason the stimulus includes wrap-around at lane edges, signed extremes and saturation on both sides, so that a misplaced bit shows in the first result that uses it.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    localparam int DATA_W  = 64;
    localparam int OP_W    = 3;
    localparam int SZ_W    = 2;
    localparam int N_SIZES = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CEQ  = 3'd2,
        OP_CGT  = 3'd3,
        OP_MIXO = 3'd4,
        OP_PACK = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [SZ_W-1:0] {
        SZ_B   = 2'd0,
        SZ_H   = 2'd1,
        SZ_WD  = 2'd2,
        SZ_RSV = 2'd3
    } lsz_e;

    typedef struct packed {
        logic              ok;
        logic [DATA_W-1:0] data;
    } res_t;

    function automatic logic op_legal(op_e op, lsz_e sz);
        logic r;
        r = (sz != SZ_RSV);
        case (op)
            OP_ADD, OP_SUB, OP_CEQ, OP_CGT, OP_MIXO: ;
            OP_PACK: r = r && (sz != SZ_B);
            default: r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pmx_lane_alu.sv
module pmx_lane_alu
    import pmx_pkg::*;
#(
    parameter int DW     = 64,
    parameter int LANE_W = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res
);
    localparam int N_LANES = DW / LANE_W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] la, lb, lr;
        assign la = a[i*LANE_W +: LANE_W];
        assign lb = b[i*LANE_W +: LANE_W];
        always_comb begin
            case (op)
                OP_ADD:  lr = la + lb;
                OP_SUB:  lr = la - lb;
                OP_CEQ:  lr = (la == lb) ? '1 : '0;
                OP_CGT:  lr = ($signed(la) > $signed(lb)) ? '1 : '0;
                default: lr = '0;
            endcase
        end
        assign res[i*LANE_W +: LANE_W] = lr;
    end
endmodule

// File: rtl/pmx_shuffle.sv
module pmx_shuffle #(
    parameter int DW = 64
) (
    input  logic [DW-1:0]      a,
    input  logic [DW-1:0]      b,
    output logic [2:0][DW-1:0] mix_res,
    output logic [1:0][DW-1:0] pack_res
);
    // odd-lane interleave for each lane width
    for (genvar s = 0; s < 3; s++) begin : g_mix
        localparam int W = 8 << s;
        localparam int N = DW / W;
        for (genvar k = 0; k < N / 2; k++) begin : g_pair
            assign mix_res[s][(2*k+1)*W +: W] = a[(2*k+1)*W +: W];
            assign mix_res[s][(2*k)*W   +: W] = b[(2*k+1)*W +: W];
        end
    end

    // saturating narrow: p=0 -> 16 to 8, p=1 -> 32 to 16
    for (genvar p = 0; p < 2; p++) begin : g_pack
        localparam int W = 16 << p;
        localparam int H = W / 2;
        localparam int N = DW / W;
        for (genvar i = 0; i < 2 * N; i++) begin : g_lane
            logic [W-1:0]   x;
            logic [H:0]     top;
            logic [H-1:0]   y;
            if (i < N) begin : g_a
                assign x = a[i*W +: W];
            end else begin : g_b
                assign x = b[(i-N)*W +: W];
            end
            assign top = x[W-1:H-1];
            always_comb begin
                if (&top || ~|top)
                    y = x[H-1:0];
                else if (x[W-1])
                    y = {1'b1, {(H-1){1'b0}}};
                else
                    y = {1'b0, {(H-1){1'b1}}};
            end
            assign pack_res[p][i*H +: H] = y;
        end
    end
endmodule

// File: rtl/pmx_alu.sv
module pmx_alu
    import pmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [SZ_W-1:0]   lane_sz,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);
    op_e  op;
    lsz_e sz;
    assign op = op_e'(opcode);
    assign sz = lsz_e'(lane_sz);

    logic [N_SIZES-1:0][DATA_W-1:0] arith;
    logic [2:0][DATA_W-1:0]         mixr;
    logic [1:0][DATA_W-1:0]         packr;

    for (genvar s = 0; s < N_SIZES; s++) begin : g_arith
        pmx_lane_alu #(.DW(DATA_W), .LANE_W(8 << s)) u_lane (
            .op (op),
            .a  (src_a),
            .b  (src_b),
            .res(arith[s])
        );
    end

    pmx_shuffle #(.DW(DATA_W)) u_shuf (
        .a       (src_a),
        .b       (src_b),
        .mix_res (mixr),
        .pack_res(packr)
    );

    res_t nxt;
    always_comb begin
        nxt.ok   = op_legal(op, sz);
        nxt.data = '0;
        if (nxt.ok) begin
            case (op)
                OP_MIXO: begin
                    case (sz)
                        SZ_B:    nxt.data = mixr[0];
                        SZ_H:    nxt.data = mixr[1];
                        default: nxt.data = mixr[2];
                    endcase
                end
                OP_PACK: nxt.data = (sz == SZ_H) ? packr[0] : packr[1];
                default: begin
                    case (sz)
                        SZ_B:    nxt.data = arith[0];
                        SZ_H:    nxt.data = arith[1];
                        default: nxt.data = arith[2];
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= nxt.data;
                out_illegal <= ~nxt.ok;
            end
        end
    end
endmodule

// File: rtl/pmx_alu_chk.sv
module pmx_alu_chk
    import pmx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   opcode,
    input logic [SZ_W-1:0]   lane_sz,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_illegal
);
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_illegal))); // R10

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_result == '0)); // R9

    AST_RSV_SIZE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_sz == 2'd3) |=> out_illegal); // R9

    AST_EQ_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'd2 && lane_sz != 2'd3 && src_a == src_b)
        |=> (out_result == '1)); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && out_result == '0)); // R11
endmodule

bind pmx_alu pmx_alu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .opcode     (opcode),
    .lane_sz    (lane_sz),
    .src_a      (src_a),
    .src_b      (src_b),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_illegal(out_illegal)
);

// File: tb/sim_pmx_alu.sv
`timescale 1ns/1ps
module sim_pmx_alu;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  opcode;
    logic [1:0]  lane_sz;
    logic [63:0] src_a, src_b;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_illegal;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pmx_alu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .lane_sz(lane_sz), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic longint unsigned lane_get(logic [63:0] v, int i, int w);
        longint unsigned m;
        m = (w == 64) ? '1 : ((64'd1 << w) - 1);
        return (v >> (i * w)) & m;
    endfunction

    function automatic longint sx(longint unsigned x, int w);
        longint unsigned s;
        s = 64'd1 << (w - 1);
        return longint'((x ^ s) - s);
    endfunction

    function automatic logic ref_legal(logic [2:0] op, logic [1:0] sz);
        if (sz == 2'd3 || op > 3'd5) return 1'b0;
        if (op == 3'd5 && sz == 2'd0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [63:0] ref_model(logic [2:0] op, logic [1:0] sz,
                                              logic [63:0] a, logic [63:0] b);
        logic [63:0] r;
        int w, n, h;
        longint unsigned m, x, y, v;
        longint sa, sb, lo, hi;
        r = '0;
        if (!ref_legal(op, sz)) return r;
        w = 8 << sz;
        n = 64 / w;
        m = (64'd1 << w) - 1;
        if (op == 3'd5) begin
            h = w / 2;
            lo = -(longint'(1) << (h - 1));
            hi = (longint'(1) << (h - 1)) - 1;
            for (int i = 0; i < 2 * n; i++) begin
                sa = sx((i < n) ? lane_get(a, i, w) : lane_get(b, i - n, w), w);
                if (sa > hi) sa = hi;
                if (sa < lo) sa = lo;
                v = longint'(sa) & ((64'd1 << h) - 1);
                r = r | (64'(v) << (i * h));
            end
            return r;
        end
        for (int i = 0; i < n; i++) begin
            x = lane_get(a, i, w);
            y = lane_get(b, i, w);
            sa = sx(x, w);
            sb = sx(y, w);
            case (op)
                3'd0: v = (x + y) & m;
                3'd1: v = (x - y) & m;
                3'd2: v = (x == y) ? m : 0;
                3'd3: v = (sa > sb) ? m : 0;
                default: v = (i % 2 == 1) ? lane_get(a, i, w) : lane_get(b, i + 1, w);
            endcase
            r = r | (64'(v) << (i * w));
        end
        return r;
    endfunction

    function automatic string req_tag(logic [2:0] op, logic [1:0] sz);
        if (!ref_legal(op, sz)) return "R9";
        case (op)
            3'd0: return "R2/R1";
            3'd1: return "R3/R1";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R7/R8";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [2:0] op, logic [1:0] sz, logic [63:0] a, logic [63:0] b);
        logic [63:0] e;
        logic        il;
        @(negedge clk);
        in_valid = 1'b1; opcode = op; lane_sz = sz; src_a = a; src_b = b;
        e  = ref_model(op, sz, a, b);
        il = ~ref_legal(op, sz);
        @(negedge clk);
        in_valid = 1'b0;
        check({req_tag(op, sz), " result"}, out_result, e);
        check("R10 valid", 64'(out_valid), 64'd1);
        check("R9 flag", 64'(out_illegal), 64'(il));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] held;
        logic        held_il;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; opcode = '0; lane_sz = '0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 valid", 64'(out_valid), 64'd0);
        check("R11 result", out_result, 64'd0);
        check("R11 flag", 64'(out_illegal), 64'd0);
        rst = 1'b0;

        // R2 byte wrap, no carry into neighbour
        run_op(3'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
        check("R2 wrap", out_result, 64'h0000_0000_0000_0000);
        // R3 borrow stays inside lane
        run_op(3'd1, 2'd1, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001);
        check("R3 borrow", out_result, 64'h0000_FFFF_0000_FFFF);
        // R5 signed: 0x7F > 0x80, 0x80 not > 0x7F
        run_op(3'd3, 2'd0, 64'h7F80_0000_0000_0000, 64'h807F_0000_0000_0000);
        check("R5 signed", out_result, 64'hFF00_0000_0000_0000);
        // R4 word compare
        run_op(3'd2, 2'd2, 64'h1234_5678_0000_0001, 64'h1234_5678_0000_0002);
        check("R4 mask", out_result, 64'hFFFF_FFFF_0000_0000);
        // R6 odd-lane interleave bytes
        run_op(3'd4, 2'd0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0);
        check("R6 mix", out_result, 64'hA7B7_A5B5_A3B3_A1B1);
        // R7/R8 pack 16->8 with clamps
        run_op(3'd5, 2'd1, 64'h8000_7FFF_FF80_007F, 64'h0100_FEFF_0005_FFFF);
        check("R8 clamp16", out_result, 64'h7F80_05FF_807F_807F);
        // R7/R8 pack 32->16
        run_op(3'd5, 2'd2, 64'h0001_0000_FFFF_8000, 64'h0000_1234_8000_0000);
        check("R8 clamp32", out_result, 64'h1234_8000_7FFF_8000);
        // R9 illegal combinations
        run_op(3'd6, 2'd0, '1, '1);
        run_op(3'd7, 2'd2, '1, '1);
        run_op(3'd0, 2'd3, '1, '1);
        run_op(3'd5, 2'd0, '1, '1);

        // R10 hold while idle
        run_op(3'd0, 2'd2, 64'h1111_1111_2222_2222, 64'h0000_0001_0000_0001);
        held = out_result; held_il = out_illegal;
        @(negedge clk);
        in_valid = 1'b0; opcode = 3'd7; src_a = '1; src_b = '0;
        @(negedge clk);
        check("R10 idle valid", 64'(out_valid), 64'd0);
        check("R10 idle hold", out_result, held);
        check("R10 idle flag", 64'(out_illegal), 64'(held_il));

        // random mix
        for (int t = 0; t < 1500; t++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = ($urandom_range(0, 3) == 0) ? ra ^ (64'd1 << $urandom_range(0, 63))
                                              : {$urandom, $urandom};
            if ($urandom_range(0, 7) == 0) rb = ra;
            run_op(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), ra, rb);
        end

        // R11 reset mid-run
        run_op(3'd0, 2'd0, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 result after rst", out_result, 64'd0);
        check("R11 valid after rst", 64'(out_valid), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule